// File: doc/BRIEF.md
# Snapshot-and-Clear Path Error Counters

This block keeps two error-event counters for each tributary of a low-order path monitor. One counts BIP error events and the other counts frames that carry a remote error indication. An upstream overhead decoder supplies one strobe per event for each tributary. A host reaches the counters over a byte-wide bus.

To read a counter, the host writes to that counter's high-byte address. In a single cycle, the write copies the live count into a per-counter hold register and restarts the live count. The host then reads the held value as two bytes: the high byte first, then the low byte. The live count keeps running while the held snapshot is read, so no event is lost between two readouts.

The host address has two fields. The upper nibble selects the tributary, from 1 to NUM_TRIB. The lower nibble selects the register, using these offsets:

| Offset | Register |
|---|---|
| 0 | BIP low byte |
| 1 | BIP high byte, which is also the BIP capture address |
| 2 | REI low byte |
| 3 | REI high byte, which is also the REI capture address |

Top module: `lop_err_counters`

## Requirements
- R1: Each cycle in which `bip_evt[t-1]` is high adds one to the live BIP count of tributary t. The live BIP count is 12 bits wide.
- R2: Each cycle in which `rei_evt[t-1]` is high adds one to the live REI count of tributary t. The live REI count is 11 bits wide.
- R3: A cycle with `host_wr` high and an address of tributary t with offset 1 (BIP) or offset 3 (REI) does two things to that counter. It loads the hold register with the live count as it stood before that edge, and it restarts the live count from zero. No other counter is changed.
- R4: An event strobe in the same cycle as the capture of its counter is not lost. The restarted live count becomes 1 instead of 0.
- R5: A live count that reaches its all-ones value stays there while further events arrive. The BIP limit is 4095 and the REI limit is 2047.
- R6: A read returns its byte on `rd_data` one cycle after `host_rd`. The four offsets return these bytes:
  - Offset 0 returns hold bits 7:0 of the BIP counter.
  - Offset 1 returns the BIP hold bits 11:8 in bits 3:0, with bits 7:4 at zero.
  - Offset 2 returns hold bits 7:0 of the REI counter.
  - Offset 3 returns the REI hold bits 10:8 in bits 2:0, with bits 7:3 at zero.
- R7: The following accesses have no effect on any counter, and a read of them returns 0:
  - tributary field 0,
  - a tributary field above NUM_TRIB,
  - offsets 4 to 15.
  A write to a low-byte offset (0 or 2) captures nothing.
- R8: While `rst` is high, every live count, every hold register and `rd_data` are cleared to zero.
- R9: `rd_data` keeps its value in every cycle without `host_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bip_evt | input | NUM_TRIB | BIP error strobes; bit t-1 belongs to tributary t |
| rei_evt | input | NUM_TRIB | REI frame strobes; bit t-1 belongs to tributary t |
| host_addr | input | TRIB_W+4 | Host address: tributary in the upper TRIB_W bits, offset in the lower 4 bits |
| host_wr | input | 1 | Host write strobe, one cycle; a write to a high-byte offset captures the counter |
| host_rd | input | 1 | Host read strobe, one cycle |
| rd_data | output | DATA_W | Registered read byte |

## Verification
The assertions assume two things about the inputs. First, `host_wr` and `host_rd` are single-cycle strobes with a stable address in that cycle. Second, the event strobes are synchronous to `clk`, with at most one event per counter per cycle.

The stimulus drives every input once per cycle at the falling edge. Random writes and reads span every tributary value, including 0, and offsets 0 to 4, so the accesses that must be ignored also occur. Directed sequences add the cases that random stimulus rarely reaches:
- long event runs that drive both counter types into saturation,
- an event landing on the same edge as its capture,
- a second capture that shows the live count restarted.

// File: rtl/lop_err_pkg.sv
package lop_err_pkg;
  localparam int unsigned OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_BIP_LO = 4'd0;
  localparam logic [OFS_W-1:0] OFS_BIP_HI = 4'd1;
  localparam logic [OFS_W-1:0] OFS_REI_LO = 4'd2;
  localparam logic [OFS_W-1:0] OFS_REI_HI = 4'd3;
endpackage

// File: rtl/lop_sat_counter.sv
module lop_sat_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic         clr,
  output logic [W-1:0] hold_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] live;

  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= '0;
      hold_o <= '0;
    end else if (clr) begin
      hold_o <= live;
      live   <= W'(evt);
    end else if (evt && live != MAXV) begin
      live <= live + W'(1);
    end
  end

  // R1 R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && evt && live != MAXV) |=> live == $past(live) + W'(1));
  // R5
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && live == MAXV) |=> live == MAXV);
  // R3
  snapshot_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> hold_o == $past(live));
  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> live == W'($past(evt)));
  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> $stable(hold_o));
endmodule

// File: rtl/lop_trib_channel.sv
module lop_trib_channel
  import lop_err_pkg::*;
#(
  parameter int unsigned TRIB_ID = 1,
  parameter int unsigned TRIB_W  = 4,
  parameter int unsigned BIP_W   = 12,
  parameter int unsigned REI_W   = 11,
  localparam int unsigned ADDR_W = TRIB_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bip_evt,
  input  logic              rei_evt,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  output logic [BIP_W-1:0]  bip_hold,
  output logic [REI_W-1:0]  rei_hold
);
  logic             hit;
  logic [OFS_W-1:0] ofs;
  logic             cap_bip, cap_rei;

  assign hit     = host_addr[ADDR_W-1:OFS_W] == TRIB_W'(TRIB_ID);
  assign ofs     = host_addr[OFS_W-1:0];
  assign cap_bip = host_wr && hit && ofs == OFS_BIP_HI;
  assign cap_rei = host_wr && hit && ofs == OFS_REI_HI;

  lop_sat_counter #(.W(BIP_W)) u_bip (
    .clk(clk), .rst(rst), .evt(bip_evt), .clr(cap_bip), .hold_o(bip_hold));

  lop_sat_counter #(.W(REI_W)) u_rei (
    .clk(clk), .rst(rst), .evt(rei_evt), .clr(cap_rei), .hold_o(rei_hold));

  // R7
  low_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && hit && (ofs == OFS_BIP_LO || ofs == OFS_REI_LO))
      |=> ($stable(bip_hold) && $stable(rei_hold)));
  // R3
  other_trib_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(bip_hold) && $stable(rei_hold)));
endmodule

// File: rtl/lop_read_mux.sv
module lop_read_mux
  import lop_err_pkg::*;
#(
  parameter int unsigned NUM_TRIB = 15,
  parameter int unsigned TRIB_W   = 4,
  parameter int unsigned BIP_W    = 12,
  parameter int unsigned REI_W    = 11,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned ADDR_W  = TRIB_W + OFS_W,
  localparam int unsigned EXT_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic [BIP_W-1:0]  bip_hold [NUM_TRIB],
  input  logic [REI_W-1:0]  rei_hold [NUM_TRIB],
  output logic [DATA_W-1:0] rd_data
);
  logic [TRIB_W-1:0] trib;
  logic [OFS_W-1:0]  ofs;
  logic [BIP_W-1:0]  sel_bip;
  logic [REI_W-1:0]  sel_rei;
  logic [EXT_W-1:0]  bip_ext, rei_ext;
  logic [DATA_W-1:0] byte_sel;

  assign trib = host_addr[ADDR_W-1:OFS_W];
  assign ofs  = host_addr[OFS_W-1:0];

  always_comb begin
    sel_bip = '0;
    sel_rei = '0;
    for (int i = 0; i < NUM_TRIB; i++) begin
      if (trib == TRIB_W'(i + 1)) begin
        sel_bip = bip_hold[i];
        sel_rei = rei_hold[i];
      end
    end
    bip_ext = EXT_W'(sel_bip);
    rei_ext = EXT_W'(sel_rei);
    case (ofs)
      OFS_BIP_LO: byte_sel = bip_ext[DATA_W-1:0];
      OFS_BIP_HI: byte_sel = bip_ext[EXT_W-1:DATA_W];
      OFS_REI_LO: byte_sel = rei_ext[DATA_W-1:0];
      OFS_REI_HI: byte_sel = rei_ext[EXT_W-1:DATA_W];
      default:    byte_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (host_rd) rd_data <= byte_sel;
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(rd_data));
  // R6
  bip_hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && ofs == OFS_BIP_HI) |=> (rd_data >> (BIP_W - DATA_W)) == '0);
  // R6
  rei_hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && ofs == OFS_REI_HI) |=> (rd_data >> (REI_W - DATA_W)) == '0);
  // R7
  trib_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && trib == '0) |=> rd_data == '0);
endmodule

// File: rtl/lop_err_counters.sv
module lop_err_counters
  import lop_err_pkg::*;
#(
  parameter int unsigned NUM_TRIB = 15,
  parameter int unsigned TRIB_W   = 4,
  parameter int unsigned BIP_W    = 12,
  parameter int unsigned REI_W    = 11,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned ADDR_W  = TRIB_W + OFS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIB-1:0] bip_evt,
  input  logic [NUM_TRIB-1:0] rei_evt,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                host_wr,
  input  logic                host_rd,
  output logic [DATA_W-1:0]   rd_data
);
  logic [BIP_W-1:0] bip_hold [NUM_TRIB];
  logic [REI_W-1:0] rei_hold [NUM_TRIB];

  for (genvar g = 0; g < NUM_TRIB; g++) begin : g_trib
    lop_trib_channel #(
      .TRIB_ID(g + 1), .TRIB_W(TRIB_W), .BIP_W(BIP_W), .REI_W(REI_W)
    ) u_chan (
      .clk(clk), .rst(rst),
      .bip_evt(bip_evt[g]), .rei_evt(rei_evt[g]),
      .host_addr(host_addr), .host_wr(host_wr),
      .bip_hold(bip_hold[g]), .rei_hold(rei_hold[g]));
  end

  lop_read_mux #(
    .NUM_TRIB(NUM_TRIB), .TRIB_W(TRIB_W), .BIP_W(BIP_W),
    .REI_W(REI_W), .DATA_W(DATA_W)
  ) u_mux (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .bip_hold(bip_hold), .rei_hold(rei_hold), .rd_data(rd_data));

  // R8
  reset_out_chk: assert property (@(posedge clk) rst |=> rd_data == '0);
endmodule

// File: tb/lop_err_counters_bench.sv
module lop_err_counters_bench;
  localparam int NT = 15;
  localparam int BIP_MAX = 4095;
  localparam int REI_MAX = 2047;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic [NT-1:0] bip_evt, rei_evt;
  logic [7:0]    host_addr;
  logic          host_wr, host_rd;
  logic [7:0]    rd_data;

  lop_err_counters u_lop_err_counters (
    .clk(clk), .rst(rst), .bip_evt(bip_evt), .rei_evt(rei_evt),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .rd_data(rd_data));

  int m_bip_live [NT];
  int m_bip_hold [NT];
  int m_rei_live [NT];
  int m_rei_hold [NT];
  int checks = 0;
  int errors = 0;
  int last_rd = 0;
  bit done = 1'b0;

  function automatic int exp_read(logic [7:0] a);
    int t;
    t = int'(a[7:4]);
    if (t == 0 || t > NT) return 0;
    case (a[3:0])
      4'd0: return m_bip_hold[t-1] & 255;
      4'd1: return (m_bip_hold[t-1] >> 8) & 15;
      4'd2: return m_rei_hold[t-1] & 255;
      4'd3: return (m_rei_hold[t-1] >> 8) & 7;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic do_cycle(input logic [NT-1:0] be, input logic [NT-1:0] re,
                          input logic [7:0] a, input bit wr, input bit rd,
                          input string tag);
    int expv;
    int t;
    @(negedge clk);
    bip_evt = be; rei_evt = re; host_addr = a; host_wr = wr; host_rd = rd;
    expv = exp_read(a);
    @(posedge clk);
    for (int i = 0; i < NT; i++) begin
      t = i + 1;
      if (wr && int'(a[7:4]) == t && a[3:0] == 4'd1) begin   // R3 R4
        m_bip_hold[i] = m_bip_live[i];
        m_bip_live[i] = be[i] ? 1 : 0;
      end else if (be[i] && m_bip_live[i] < BIP_MAX) m_bip_live[i]++;  // R1 R5
      if (wr && int'(a[7:4]) == t && a[3:0] == 4'd3) begin
        m_rei_hold[i] = m_rei_live[i];
        m_rei_live[i] = re[i] ? 1 : 0;
      end else if (re[i] && m_rei_live[i] < REI_MAX) m_rei_live[i]++;  // R2 R5
    end
    #5;
    if (rd) begin
      chk(int'(rd_data) == expv, tag, int'(rd_data), expv);
      last_rd = expv;
    end else begin
      chk(int'(rd_data) == last_rd, "R9", int'(rd_data), last_rd);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_cycle('0, '0, 8'h00, 1'b0, 1'b0, "R9");
  endtask

  task automatic read_pair(input int trib, input int hi_ofs, input string tag);
    do_cycle('0, '0, 8'((trib << 4) | hi_ofs), 1'b0, 1'b1, tag);
    do_cycle('0, '0, 8'((trib << 4) | (hi_ofs - 1)), 1'b0, 1'b1, tag);
  endtask

  task automatic capture(input int trib, input int hi_ofs,
                         input logic [NT-1:0] be, input logic [NT-1:0] re);
    do_cycle(be, re, 8'((trib << 4) | hi_ofs), 1'b1, 1'b0, "R3");
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < NT; i++) begin
      m_bip_live[i] = 0; m_bip_hold[i] = 0; m_rei_live[i] = 0; m_rei_hold[i] = 0;
    end
    rst = 1'b1; bip_evt = '0; rei_evt = '0; host_addr = '0; host_wr = 0; host_rd = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(rd_data == 8'd0, "R8", int'(rd_data), 0);
    read_pair(1, 1, "R8");
    read_pair(NT, 3, "R8");

    // R1 R2: five BIP and four REI events on tributary 3
    for (int i = 0; i < 5; i++)
      do_cycle(NT'(1 << 2), (i < 4) ? NT'(1 << 2) : '0, 8'h00, 1'b0, 1'b0, "R1");
    // R7: writes that must not capture
    do_cycle('0, '0, 8'h30, 1'b1, 1'b0, "R7");
    do_cycle('0, '0, 8'h01, 1'b1, 1'b0, "R7");
    do_cycle('0, '0, 8'h37, 1'b1, 1'b0, "R7");
    do_cycle('0, '0, 8'h03, 1'b0, 1'b1, "R7");
    do_cycle('0, '0, 8'h3A, 1'b0, 1'b1, "R7");
    capture(3, 1, '0, '0);
    read_pair(3, 1, "R1");
    chk(m_bip_hold[2] == 5, "R1", m_bip_hold[2], 5);
    capture(3, 3, '0, '0);
    read_pair(3, 3, "R2");
    // R3: live count restarted after capture
    do_cycle(NT'(1 << 2), '0, 8'h00, 1'b0, 1'b0, "R3");
    do_cycle(NT'(1 << 2), '0, 8'h00, 1'b0, 1'b0, "R3");
    capture(3, 1, '0, '0);
    read_pair(3, 1, "R3");

    // R4: event on the capture edge
    for (int i = 0; i < 3; i++) do_cycle(NT'(1 << 4), '0, 8'h00, 1'b0, 1'b0, "R4");
    capture(5, 1, NT'(1 << 4), '0);
    read_pair(5, 1, "R4");
    capture(5, 1, '0, '0);
    read_pair(5, 1, "R4");

    // R5: saturation of both counter types
    for (int i = 0; i < 2050; i++) do_cycle('0, NT'(1 << 14), 8'h00, 1'b0, 1'b0, "R5");
    capture(15, 3, '0, '0);
    read_pair(15, 3, "R5");
    for (int i = 0; i < 4100; i++) do_cycle(NT'(1), '0, 8'h00, 1'b0, 1'b0, "R5");
    capture(1, 1, '0, '0);
    read_pair(1, 1, "R5");

    // R6: mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [NT-1:0] be, re;
      int op;
      logic [7:0] a;
      for (int i = 0; i < NT; i++) begin
        be[i] = ($urandom % 4) == 0;
        re[i] = ($urandom % 5) == 0;
      end
      a  = {4'($urandom % 16), 4'($urandom % 5)};
      op = $urandom % 8;
      if (op == 0)      do_cycle(be, re, a, 1'b1, 1'b0, "R3");
      else if (op < 4)  do_cycle(be, re, a, 1'b0, 1'b1, "R6");
      else              do_cycle(be, re, a, 1'b0, 1'b0, "R9");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule